// File: doc/BRIEF.md
# Cross-Coupled Pulsed-Handshake Byte Link

This block joins two bus masters through a pair of identical parallel endpoints wired back to back. Each master sees four byte-wide registers: a transmit latch, a receive holder, and two status registers. Each endpoint's transmit latch and strobe line feed the other endpoint's receive path. Each endpoint's acknowledge line feeds the other endpoint's transmit status. This gives two independent simplex byte channels, one in each direction. Flow control is fully polled and no interrupt is ever produced.

A transfer works as follows. The sender writes its transmit latch, and its strobe line drops for one clock. The strobe's rising edge is synchronised on the far side, captures the byte and raises the receive flag. The receiver polls that flag and then reads the byte. That read clears the flag and drops the receiver's acknowledge line for one clock. The acknowledge's rising edge raises the transmit flag on the sender. The sender then reads its transmit latch to clear that flag and discards the value it gets.

The register ports have no valid/ready back-pressure. A master must poll the flags instead. A transmit write that arrives while the transmit flag is set is refused silently. A receiver that does not read in time loses the newer byte and records an overrun.

Top module: `hs_link_pair`

## Requirements
- R1: After reset, every status register on both sides reads 0x00 and all four strobe and acknowledge lines are high.
- R2: A write to the transmit latch (address 2) is accepted when the transmit flag and the strobe are idle. On acceptance, that side's strobe goes low for exactly one clock, starting the cycle after the write.
- R3: The rising edge of an incoming strobe captures the incoming byte into the receive holder (address 0) and sets bit 7 of the receive status (address 1). Bits 5..0 of the receive status always read 0.
- R4: Reading the receive status has no side effect: the flags do not change and no acknowledge pulse is produced.
- R5: Reading the receive holder while bit 7 of the receive status is set returns the byte, clears that bit, and drives the acknowledge line low for exactly one clock, starting the cycle after the read.
- R6: Reading the receive holder while the receive flag is clear returns the last byte and has no effect: no acknowledge pulse and no flag change.
- R7: The rising edge of an incoming acknowledge sets bit 7 of the transmit status (address 3). Bits 6..0 of the transmit status always read 0.
- R8: Reading the transmit latch (address 2) returns the last accepted byte and clears the transmit flag.
- R9: A write to the transmit latch while the transmit flag is set is ignored: no strobe, and the latch keeps its byte.
- R10: A strobe edge that arrives while the receive flag is set leaves the flag set, keeps the held byte, and sets the sticky overrun bit 6 of the receive status. Only a write to the receive status with bit 6 set, or reset, clears the overrun bit.
- R11: The two directions are independent: transfers started on both sides at once both arrive, and a stream of bytes in each direction arrives complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Clock of side A |
| a_rst_n | input | 1 | Active-low reset of side A |
| a_addr | input | 2 | Side A register select |
| a_wr | input | 1 | Side A register write |
| a_rd | input | 1 | Side A register read (side effects at the clock edge) |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A read data (combinational from a_addr) |
| a_strb_n | output | 1 | Side A strobe toward B |
| a_ack_n | output | 1 | Side A acknowledge toward B |
| b_clk | input | 1 | Clock of side B |
| b_rst_n | input | 1 | Active-low reset of side B |
| b_addr | input | 2 | Side B register select |
| b_wr | input | 1 | Side B register write |
| b_rd | input | 1 | Side B register read |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B read data |
| b_strb_n | output | 1 | Side B strobe toward A |
| b_ack_n | output | 1 | Side B acknowledge toward A |

## Verification
The bench builds the link with its defaults: an 8-bit data path and a two-stage synchroniser. Both sides run from one 250 MHz clock. With a shared clock, the single-cycle width of the strobe and acknowledge pulses, and the cycle in which each one starts, can be sampled exactly at the ports. The short synchroniser brings a second write well within the receiver's window, which makes overrun and refused-write cases easy to reach. Streams in each direction go through a queue-based scoreboard, which covers byte order and values including 0x00 and 0xFF.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;

  // Register selects seen by each bus master
  typedef enum logic [1:0] {
    SEL_RX_HOLD = 2'd0,
    SEL_RX_STAT = 2'd1,
    SEL_TX_LATCH = 2'd2,
    SEL_TX_STAT = 2'd3
  } link_sel_e;

  // Status bit positions
  localparam int FLAG_POS = 7;
  localparam int OVR_POS  = 6;

endpackage

// File: rtl/hs_sync_rise.sv
// Multi-stage synchroniser on an idle-high line with a rising-edge detector.
module hs_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o,
  output logic synced_o
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= line_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b1;
    else        last <= chain[STAGES-1];
  end

  assign synced_o = chain[STAGES-1];
  assign rise_o   = chain[STAGES-1] & ~last;

endmodule

// File: rtl/hs_data_pipe.sv
// Delay line that keeps the data bus aligned with its synchronised strobe.
module hs_data_pipe #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/hs_low_pulse.sv
// Registered active-low pulse, one clock per fire request.
module hs_low_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_n <= 1'b1;
    else        pulse_n <= ~fire_i;
  end

endmodule

// File: rtl/hs_port_end.sv
// One endpoint: transmit latch with strobe, receive holder with acknowledge.
module hs_port_end
  import hs_link_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  // toward the far endpoint
  output logic [DATA_W-1:0] tx_data_o,
  output logic              strb_n_o,
  output logic              ack_n_o,
  // from the far endpoint
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              strb_n_i,
  input  logic              ack_n_i
);

  link_sel_e         sel;
  logic              rx_full, rx_ovr, tx_flag;
  logic [DATA_W-1:0] rx_hold, tx_hold, rx_cand;
  logic              strb_rise, ack_rise;
  logic              strb_lvl, ack_lvl;
  logic              rx_take, rx_stat_wr, tx_accept, tx_clear;

  assign sel = link_sel_e'(addr);

  // Incoming strobe and its data, kept in step
  hs_sync_rise #(.STAGES(SYNC_STAGES)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .line_i(strb_n_i),
    .rise_o(strb_rise), .synced_o(strb_lvl)
  );

  hs_data_pipe #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_rx_pipe (
    .clk(clk), .rst_n(rst_n), .din(rx_data_i), .dout(rx_cand)
  );

  // Incoming acknowledge
  hs_sync_rise #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .line_i(ack_n_i),
    .rise_o(ack_rise), .synced_o(ack_lvl)
  );

  // Register access decode
  assign rx_take    = rd && (sel == SEL_RX_HOLD) && rx_full && ack_n_o;
  assign rx_stat_wr = wr && (sel == SEL_RX_STAT);
  assign tx_accept  = wr && (sel == SEL_TX_LATCH) && !tx_flag && strb_n_o;
  assign tx_clear   = rd && (sel == SEL_TX_LATCH);

  // Receive side state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_hold <= '0;
    end else begin
      if (strb_rise)    rx_full <= 1'b1;
      else if (rx_take) rx_full <= 1'b0;

      if (strb_rise && rx_full && !rx_take)       rx_ovr <= 1'b1;
      else if (rx_stat_wr && wdata[OVR_POS])      rx_ovr <= 1'b0;

      if (strb_rise && (!rx_full || rx_take))     rx_hold <= rx_cand;
    end
  end

  // Transmit side state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag <= 1'b0;
      tx_hold <= '0;
    end else begin
      if (ack_rise)      tx_flag <= 1'b1;
      else if (tx_clear) tx_flag <= 1'b0;

      if (tx_accept) tx_hold <= wdata;
    end
  end

  // Outgoing pulses
  hs_low_pulse u_strb_gen (
    .clk(clk), .rst_n(rst_n), .fire_i(tx_accept), .pulse_n(strb_n_o)
  );

  hs_low_pulse u_ack_gen (
    .clk(clk), .rst_n(rst_n), .fire_i(rx_take), .pulse_n(ack_n_o)
  );

  assign tx_data_o = tx_hold;

  // Read mux; the synchronised line levels are not exposed
  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_RX_HOLD:  rdata = rx_hold;
      SEL_RX_STAT: begin
        rdata[FLAG_POS] = rx_full;
        rdata[OVR_POS]  = rx_ovr;
      end
      SEL_TX_LATCH: rdata = tx_hold;
      SEL_TX_STAT:  rdata[FLAG_POS] = tx_flag;
      default:      rdata = '0;
    endcase
  end

  logic unused_lvl;
  assign unused_lvl = strb_lvl ^ ack_lvl;

endmodule

// File: rtl/hs_link_pair.sv
// Two endpoints with strobe, acknowledge and data lines cross-coupled.
module hs_link_pair #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic [1:0]        a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_strb_n,
  output logic              a_ack_n,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic [1:0]        b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_strb_n,
  output logic              b_ack_n
);

  logic [DATA_W-1:0] a_to_b, b_to_a;

  hs_port_end #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_side_a (
    .clk(a_clk), .rst_n(a_rst_n),
    .addr(a_addr), .wr(a_wr), .rd(a_rd), .wdata(a_wdata), .rdata(a_rdata),
    .tx_data_o(a_to_b), .strb_n_o(a_strb_n), .ack_n_o(a_ack_n),
    .rx_data_i(b_to_a), .strb_n_i(b_strb_n), .ack_n_i(b_ack_n)
  );

  hs_port_end #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_side_b (
    .clk(b_clk), .rst_n(b_rst_n),
    .addr(b_addr), .wr(b_wr), .rd(b_rd), .wdata(b_wdata), .rdata(b_rdata),
    .tx_data_o(b_to_a), .strb_n_o(b_strb_n), .ack_n_o(b_ack_n),
    .rx_data_i(a_to_b), .strb_n_i(a_strb_n), .ack_n_i(a_ack_n)
  );

endmodule

// File: rtl/hs_link_checker.sv
module hs_link_checker #(
  parameter int DATA_W = 8
) (
  input logic              a_clk,
  input logic              a_rst_n,
  input logic [1:0]        a_addr,
  input logic              a_wr,
  input logic              a_rd,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_strb_n,
  input logic              a_ack_n,
  input logic              b_clk,
  input logic              b_rst_n,
  input logic [1:0]        b_addr,
  input logic              b_wr,
  input logic              b_rd,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_strb_n,
  input logic              b_ack_n
);

  // R2: strobe lasts one clock and follows a transmit-latch write
  a_r2_strb_single_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    $fell(a_strb_n) |=> a_strb_n);
  a_r2_strb_cause_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    $fell(a_strb_n) |-> $past(a_wr && a_addr == 2'd2));
  a_r2_strb_single_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    $fell(b_strb_n) |=> b_strb_n);
  a_r2_strb_cause_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    $fell(b_strb_n) |-> $past(b_wr && b_addr == 2'd2));

  // R5: acknowledge lasts one clock and follows a receive-holder read
  a_r5_ack_single_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    $fell(a_ack_n) |=> a_ack_n);
  a_r5_ack_cause_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    $fell(a_ack_n) |-> $past(a_rd && a_addr == 2'd0));
  a_r5_ack_single_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    $fell(b_ack_n) |=> b_ack_n);
  a_r5_ack_cause_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    $fell(b_ack_n) |-> $past(b_rd && b_addr == 2'd0));

  // R3: low receive-status bits are always zero
  a_r3_rx_stat_pad_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_addr == 2'd1) |-> (a_rdata[5:0] == 6'd0));
  a_r3_rx_stat_pad_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (b_addr == 2'd1) |-> (b_rdata[5:0] == 6'd0));

  // R7: transmit status carries only its flag
  a_r7_tx_stat_pad_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_addr == 2'd3) |-> (a_rdata[6:0] == 7'd0));
  a_r7_tx_stat_pad_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (b_addr == 2'd3) |-> (b_rdata[6:0] == 7'd0));

endmodule

bind hs_link_pair hs_link_checker #(.DATA_W(DATA_W)) u_chk (
  .a_clk(a_clk), .a_rst_n(a_rst_n), .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd),
  .a_rdata(a_rdata), .a_strb_n(a_strb_n), .a_ack_n(a_ack_n),
  .b_clk(b_clk), .b_rst_n(b_rst_n), .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd),
  .b_rdata(b_rdata), .b_strb_n(b_strb_n), .b_ack_n(b_ack_n)
);

// File: tb/sim_hs_link_pair.sv
module sim_hs_link_pair;

  localparam logic [1:0] RXH = 2'd0, RXS = 2'd1, TXL = 2'd2, TXS = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] a_addr, b_addr;
  logic       a_wr, a_rd, b_wr, b_rd;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic       a_strb_n, a_ack_n, b_strb_n, b_ack_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] q_ab[$];
  logic [7:0] q_ba[$];

  always #2 clk = ~clk;

  hs_link_pair u0 (
    .a_clk(clk), .a_rst_n(rst_n), .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_strb_n(a_strb_n), .a_ack_n(a_ack_n),
    .b_clk(clk), .b_rst_n(rst_n), .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_strb_n(b_strb_n), .b_ack_n(b_ack_n)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_rd(input bit side, input logic [1:0] ad, output logic [7:0] d);
    @(negedge clk);
    if (!side) begin a_addr = ad; a_rd = 1'b1; end
    else       begin b_addr = ad; b_rd = 1'b1; end
    #1 d = side ? b_rdata : a_rdata;
    @(posedge clk);
    #1;
    if (!side) a_rd = 1'b0; else b_rd = 1'b0;
  endtask

  task automatic reg_wr(input bit side, input logic [1:0] ad, input logic [7:0] v);
    @(negedge clk);
    if (!side) begin a_addr = ad; a_wdata = v; a_wr = 1'b1; end
    else       begin b_addr = ad; b_wdata = v; b_wr = 1'b1; end
    @(posedge clk);
    #1;
    if (!side) a_wr = 1'b0; else b_wr = 1'b0;
  endtask

  task automatic poll_flag(input bit side, input logic [1:0] ad, input string req);
    logic [7:0] d;
    bit seen = 1'b0;
    for (int n = 0; n < 40 && !seen; n++) begin
      reg_rd(side, ad, d);
      seen = d[7];
    end
    check8(req, {7'd0, seen}, 8'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Driver: queue the expected byte, send it, then finish the acknowledge
  task automatic send(input bit side, input logic [7:0] v);
    logic [7:0] d;
    if (!side) q_ab.push_back(v); else q_ba.push_back(v);
    reg_wr(side, TXL, v);
    poll_flag(side, TXS, "R7 ack flag in stream");
    reg_rd(side, TXL, d);
    check8("R8 latch readback in stream", d, v);
  endtask

  // Monitor: take bytes as they arrive and compare against the queue
  task automatic recv(input bit side, input int n);
    logic [7:0] d, e;
    for (int i = 0; i < n; i++) begin
      poll_flag(side, RXS, "R11 stream arrival");
      reg_rd(side, RXH, d);
      if (side) e = (q_ab.size() > 0) ? q_ab.pop_front() : 8'hxx;
      else      e = (q_ba.size() > 0) ? q_ba.pop_front() : 8'hxx;
      check8("R11 stream byte", d, e);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0;
    a_addr = 2'd0; b_addr = 2'd0;
    a_wr = 1'b0; a_rd = 1'b0; b_wr = 1'b0; b_rd = 1'b0;
    a_wdata = 8'd0; b_wdata = 8'd0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check8("R1 lines", {4'd0, a_strb_n, a_ack_n, b_strb_n, b_ack_n}, 8'h0F);
    reg_rd(0, RXS, d); check8("R1 A rx stat", d, 8'h00);
    reg_rd(0, TXS, d); check8("R1 A tx stat", d, 8'h00);
    reg_rd(1, RXS, d); check8("R1 B rx stat", d, 8'h00);
    reg_rd(1, TXS, d); check8("R1 B tx stat", d, 8'h00);

    // R2 strobe pulse, R3 capture
    reg_wr(0, TXL, 8'h3C);
    check8("R2 strobe low after write", {7'd0, a_strb_n}, 8'h00);
    idle(1);
    check8("R2 strobe high one clock later", {7'd0, a_strb_n}, 8'h01);
    poll_flag(1, RXS, "R3 rx flag set");
    reg_rd(1, RXS, d); check8("R3 rx stat value", d, 8'h80);

    // R4 status read has no side effect
    reg_rd(1, RXS, d); check8("R4 rx stat stable", d, 8'h80);
    check8("R4 no ack", {7'd0, b_ack_n}, 8'h01);

    // R5 data read clears flag and pulses acknowledge
    reg_rd(1, RXH, d); check8("R5 byte", d, 8'h3C);
    check8("R5 ack low after read", {7'd0, b_ack_n}, 8'h00);
    idle(1);
    check8("R5 ack high one clock later", {7'd0, b_ack_n}, 8'h01);
    reg_rd(1, RXS, d); check8("R5 rx flag clear", d, 8'h00);

    // R6 empty read has no effect
    reg_rd(1, RXH, d); check8("R6 last byte", d, 8'h3C);
    check8("R6 no ack", {7'd0, b_ack_n}, 8'h01);

    // R7 sender flag
    poll_flag(0, TXS, "R7 tx flag set");

    // R9 write refused while tx flag set
    reg_wr(0, TXL, 8'h55);
    check8("R9 no strobe", {7'd0, a_strb_n}, 8'h01);
    idle(10);
    reg_rd(1, RXS, d); check8("R9 nothing received", d, 8'h00);
    reg_rd(0, TXL, d); check8("R9 latch kept", d, 8'h3C);
    reg_rd(0, TXS, d); check8("R8 tx flag cleared by latch read", d, 8'h00);

    // R10 overrun
    reg_wr(0, TXL, 8'h11);
    poll_flag(1, RXS, "R10 first byte arrives");
    reg_wr(0, TXL, 8'h22);
    idle(10);
    reg_rd(1, RXS, d); check8("R10 flag and overrun", d, 8'hC0);
    reg_rd(1, RXH, d); check8("R10 first byte kept", d, 8'h11);
    reg_rd(1, RXS, d); check8("R10 overrun sticky", d, 8'h40);
    reg_wr(1, RXS, 8'h00);
    reg_rd(1, RXS, d); check8("R10 write without bit6 keeps overrun", d, 8'h40);
    reg_wr(1, RXS, 8'h40);
    reg_rd(1, RXS, d); check8("R10 overrun cleared", d, 8'h00);
    poll_flag(0, TXS, "R7 ack after overrun read");
    reg_rd(0, TXL, d); check8("R8 latch holds second byte", d, 8'h22);
    reg_rd(0, TXS, d); check8("R8 tx flag clear", d, 8'h00);

    // R11 both directions at once
    reg_wr(0, TXL, 8'hA5);
    reg_wr(1, TXL, 8'h5A);
    poll_flag(1, RXS, "R11 B receives");
    reg_rd(1, RXH, d); check8("R11 A to B byte", d, 8'hA5);
    poll_flag(0, RXS, "R11 A receives");
    reg_rd(0, RXH, d); check8("R11 B to A byte", d, 8'h5A);
    poll_flag(0, TXS, "R11 A ack");
    reg_rd(0, TXL, d);
    poll_flag(1, TXS, "R11 B ack");
    reg_rd(1, TXL, d);

    // R11 streams with scoreboard
    fork
      begin
        for (int i = 0; i < 16; i++)
          send(0, (i == 0) ? 8'h00 : (i == 15) ? 8'hFF : 8'((i * 37 + 5) ^ (i << 4)));
      end
      recv(1, 16);
    join
    fork
      begin
        for (int i = 0; i < 16; i++)
          send(1, 8'((i * 91 + 3) ^ 8'hA0));
      end
      recv(0, 16);
    join
    reg_rd(0, RXS, d); check8("R11 A idle after streams", d, 8'h00);
    reg_rd(1, RXS, d); check8("R11 B idle after streams", d, 8'h00);
    check8("R11 queues drained", 8'(q_ab.size() + q_ba.size()), 8'h00);

    summary();
    $finish;
  end

endmodule